// File: doc/BRIEF.md
# Paged Serial Memory Command Controller

This block is the command layer behind a two-wire serial memory slave. A bit-level front-end, which is not part of this block, turns bus activity into single-cycle strobes: a Start or repeated Start, a Stop, a matched device select together with its read/write bit, a received byte, and a request for the next byte to transmit. From these strobes the controller keeps the internal word-address counter and collects written bytes into an eight-byte page buffer. It serves reads from an internal register array. Written data reaches the array only when a Stop closes a write that carried data, and it arrives there as one commit.

Each commit is followed by a write cycle whose length is a parameter counted in clock cycles. For that whole time the controller raises `busy_o` and drops every strobe, so the front-end can refuse to acknowledge. While the write-protect input is high, bytes are still accepted but nothing reaches the array. The array holds 256 or 128 bytes, selected by the address width parameter.

Top module: `pw_mem_ctl`

## Requirements
- R1: The first byte received after a write-mode select is loaded into the word-address counter. Bits [ADDR_W-1:0] of that byte are used.
- R2: Each data byte after the address goes to the counter's address, and then only the low three counter bits increment. An eight-byte page therefore wraps from its last byte back to its first, and the upper bits stay unchanged.
- R3: When more than eight data bytes arrive before Stop, a later byte replaces the earlier buffered byte at the same page position.
- R4: Buffered bytes are written to the array only when a Stop follows. A Start that comes before the Stop discards the buffer, and the array is left unchanged.
- R5: A committing Stop raises `busy_o` in the next cycle and holds it for exactly WR_CYCLES cycles. While `busy_o` is high, all strobes are ignored and `tx_data_o` holds its value.
- R6: Each `rd_req_i` in read mode loads `tx_data_o` in the next cycle with the byte at the counter, then advances the counter by one. A read with no new word address continues from the last accessed address plus one. `tx_data_o` changes only after `rd_req_i`.
- R7: Sequential reads wrap from the top address (2**ADDR_W-1) to address 0.
- R8: A write-mode select plus word address, then a repeated Start and a read-mode select, returns the byte at that word address.
- R9: With `wp_i` high at Stop, the buffered page is discarded, the array is unchanged and `busy_o` stays low. With `wp_i` low, the write proceeds.
- R10: With ADDR_W = 7, bit 7 of the word-address byte is ignored and the array holds 128 bytes.
- R11: A Stop after a word address with no data bytes starts no write cycle, so `busy_o` stays low.
- R12: After reset, `busy_o` is low, `tx_data_o` is 0, the counter is 0 and the array holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write protect, sampled at Stop |
| start_i | input | 1 | Start or repeated Start strobe |
| stop_i | input | 1 | Stop strobe |
| sel_i | input | 1 | Matched device-select strobe |
| sel_rd_i | input | 1 | Direction of the select: 1 read, 0 write |
| rx_i | input | 1 | Received-byte strobe |
| rx_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Request for the next byte to transmit |
| tx_data_o | output | 8 | Byte to transmit, valid the cycle after `rd_req_i` |
| busy_o | output | 1 | Write cycle in progress, so requests are refused |

## Verification
The assertions check on every cycle how long the write cycle lasts and what may start it. A raise of busy must follow a Stop with write protect low, and a Stop with write protect high must leave busy low. They also check that the transmit byte holds during busy and changes only after a read request. The data path can be shown only by the bench scenarios, which compare read-back bytes with a reference model. These scenarios cover page wrap and overwrite, a page abandoned by a repeated Start, writes dropped during busy, current-address and random reads, wrap at the top address, and the 128-byte variant.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WADDR,
    ST_WDATA,
    ST_READ
  } ctl_state_e;
endpackage

// File: rtl/pw_addr_ctr.sv
module pw_addr_ctr #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_page_i,
  input  logic              step_full_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] lo_inc;

  assign lo_inc = addr_q[PAGE_W-1:0] + PAGE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_q <= '0;
    else if (load_i)      addr_q <= load_val_i;
    else if (step_page_i) addr_q <= {addr_q[ADDR_W-1:PAGE_W], lo_inc};
    else if (step_full_i) addr_q <= addr_q + ADDR_W'(1);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int unsigned PAGE_W = 3,
  localparam int unsigned PAGE = 1 << PAGE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [PAGE_W-1:0]   idx_i,
  input  logic [7:0]          data_i,
  output logic [PAGE*8-1:0]   data_o,
  output logic [PAGE-1:0]     mask_o
);
  for (genvar s = 0; s < PAGE; s++) begin : g_slot
    logic [7:0] byte_q;
    logic       vld_q;
    logic       hit;

    assign hit = wr_i && (idx_i == PAGE_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end else if (hit) begin
        byte_q <= data_i;
        vld_q  <= 1'b1;
      end
    end

    assign data_o[s*8 +: 8] = byte_q;
    assign mask_o[s]        = vld_q;
  end
endmodule

// File: rtl/pw_mem_array.sv
module pw_mem_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned PAGE  = 1 << PAGE_W,
  localparam int unsigned PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [PAGE*8-1:0] page_data_i,
  input  logic [PAGE-1:0]   page_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int unsigned SLOT = g % PAGE;
    localparam int unsigned PGN  = g / PAGE;
    logic [7:0] cell_q;
    logic       we;

    assign we = commit_i && (page_i == PG_W'(PGN)) && page_mask_i[SLOT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cell_q <= '0;
      else if (we)  cell_q <= page_data_i[SLOT*8 +: 8];
    end

    assign cells[g] = cell_q;
  end

  assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/pw_wr_timer.sv
module pw_wr_timer #(
  parameter int unsigned WR_CYCLES = 625000,
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(WR_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pw_mem_ctl.sv
module pw_mem_ctl #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wp_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sel_i,
  input  logic       sel_rd_i,
  input  logic       rx_i,
  input  logic [7:0] rx_data_i,
  input  logic       rd_req_i,
  output logic [7:0] tx_data_o,
  output logic       busy_o
);
  import pw_pkg::*;

  localparam int unsigned PAGE = 1 << PAGE_W;
  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  ctl_state_e        st_q, st_d;
  logic              act, frame_end, plain;
  logic              commit, buf_clr, addr_ld, buf_wr, rd_go;
  logic [ADDR_W-1:0] addr;
  logic [PAGE*8-1:0] pg_data;
  logic [PAGE-1:0]   pg_mask;
  logic [7:0]        rd_data;
  logic [7:0]        tx_q;
  logic              tmr_busy;

  // every strobe is dropped while the write cycle runs
  assign act       = !tmr_busy;
  assign frame_end = stop_i || start_i;
  assign plain     = act && !frame_end && !sel_i;

  assign commit  = act && stop_i && (st_q == ST_WDATA) && (|pg_mask) && !wp_i;
  assign buf_clr = act && frame_end;
  assign addr_ld = plain && rx_i && (st_q == ST_WADDR);
  assign buf_wr  = plain && rx_i && (st_q == ST_WDATA);
  assign rd_go   = plain && rd_req_i && (st_q == ST_READ);

  always_comb begin
    st_d = st_q;
    if (act) begin
      if (frame_end)    st_d = ST_IDLE;
      else if (sel_i)   st_d = sel_rd_i ? ST_READ : ST_WADDR;
      else if (addr_ld) st_d = ST_WDATA;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      tx_q <= '0;
    end else begin
      st_q <= st_d;
      if (rd_go) tx_q <= rd_data;
    end
  end

  pw_addr_ctr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) i_addr_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (addr_ld),
    .load_val_i  (rx_data_i[ADDR_W-1:0]),
    .step_page_i (buf_wr),
    .step_full_i (rd_go),
    .addr_o      (addr)
  );

  pw_page_buf #(
    .PAGE_W (PAGE_W)
  ) i_page_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .wr_i   (buf_wr),
    .idx_i  (addr[PAGE_W-1:0]),
    .data_i (rx_data_i),
    .data_o (pg_data),
    .mask_o (pg_mask)
  );

  pw_mem_array #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) i_mem_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .page_i      (addr[ADDR_W-1 -: PG_W]),
    .page_data_i (pg_data),
    .page_mask_i (pg_mask),
    .rd_addr_i   (addr),
    .rd_data_o   (rd_data)
  );

  pw_wr_timer #(
    .WR_CYCLES (WR_CYCLES)
  ) i_wr_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (tmr_busy)
  );

  assign tx_data_o = tx_q;
  assign busy_o    = tmr_busy;
endmodule

// File: rtl/pw_mem_ctl_chk.sv
module pw_mem_ctl_chk #(
  parameter int unsigned WR_CYCLES = 625000,
  localparam int unsigned BC_W = $clog2(WR_CYCLES + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_i,
  input logic       stop_i,
  input logic       rd_req_i,
  input logic [7:0] tx_data_o,
  input logic       busy_o
);
  logic [BC_W-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt_q <= '0;
    else if (busy_o) bcnt_q <= bcnt_q + BC_W'(1);
    else             bcnt_q <= '0;
  end

  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt_q < BC_W'(WR_CYCLES));

  p_busy_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bcnt_q == BC_W'(WR_CYCLES));

  p_tx_hold_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(tx_data_o));

  p_busy_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i) && !$past(wp_i));

  p_wp_no_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && wp_i && !busy_o |=> !busy_o);

  p_tx_only_on_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_data_o) |-> $past(rd_req_i));
endmodule

bind pw_mem_ctl pw_mem_ctl_chk #(
  .WR_CYCLES (WR_CYCLES)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wp_i      (wp_i),
  .stop_i    (stop_i),
  .rd_req_i  (rd_req_i),
  .tx_data_o (tx_data_o),
  .busy_o    (busy_o)
);

// File: tb/test_pw_mem_ctl.sv
module test_pw_mem_ctl;
  localparam int unsigned WR_CYC = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wp_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic       sel_i = 1'b0, sel_rd_i = 1'b0, rx_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic [7:0] tx_big, tx_small;
  logic       busy_big, busy_small;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [256];

  always #4 clk_i = ~clk_i;

  pw_mem_ctl #(.ADDR_W(8), .PAGE_W(3), .WR_CYCLES(WR_CYC)) i_pw_mem_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wp_i(wp_i), .start_i(start_i), .stop_i(stop_i),
    .sel_i(sel_i), .sel_rd_i(sel_rd_i), .rx_i(rx_i), .rx_data_i(rx_data_i),
    .rd_req_i(rd_req_i), .tx_data_o(tx_big), .busy_o(busy_big));

  pw_mem_ctl #(.ADDR_W(7), .PAGE_W(3), .WR_CYCLES(WR_CYC)) i_pw_mem_ctl_small (
    .clk_i(clk_i), .rst_ni(rst_ni), .wp_i(wp_i), .start_i(start_i), .stop_i(stop_i),
    .sel_i(sel_i), .sel_rd_i(sel_rd_i), .rx_i(rx_i), .rx_data_i(rx_data_i),
    .rd_req_i(rd_req_i), .tx_data_o(tx_small), .busy_o(busy_small));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk_i); endtask
  task automatic bus_start; start_i = 1'b1; tick(); start_i = 1'b0; endtask
  task automatic bus_stop;  stop_i = 1'b1;  tick(); stop_i = 1'b0;  endtask
  task automatic bus_sel(input logic rd);
    sel_i = 1'b1; sel_rd_i = rd; tick(); sel_i = 1'b0;
  endtask
  task automatic bus_rx(input logic [7:0] b);
    rx_i = 1'b1; rx_data_i = b; tick(); rx_i = 1'b0;
  endtask
  task automatic bus_rd(output logic [7:0] b);
    rd_req_i = 1'b1; tick(); rd_req_i = 1'b0; b = tx_big;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_big) begin n++; tick(); end
  endtask

  // page write of n bytes seed, seed+1, ... starting at addr
  task automatic write_seq(input logic [7:0] addr, input int n, input logic [7:0] seed,
                           input string req);
    int cyc;
    bus_start(); bus_sel(1'b0); bus_rx(addr);
    for (int i = 0; i < n; i++) bus_rx(seed + 8'(i));
    bus_stop();
    if (!wp_i && n > 0) begin
      for (int i = 0; i < n; i++)
        model[{addr[7:3], 3'(addr[2:0] + 3'(i))}] = seed + 8'(i);
      check({req, " busy after stop"}, busy_big, 1);
      wait_idle(cyc);
      check({req, " busy length"}, cyc, WR_CYC);
    end else begin
      check({req, " no busy"}, busy_big, 0);
    end
  endtask

  task automatic rand_read(input logic [7:0] addr, output logic [7:0] b);
    bus_start(); bus_sel(1'b0); bus_rx(addr);
    bus_start(); bus_sel(1'b1); bus_rd(b);
  endtask

  task automatic t_reset;
    check("R12 busy", busy_big, 0);
    check("R12 tx", tx_big, 0);
    check("R12 small busy", busy_small, 0);
  endtask

  task automatic t_byte_write;
    logic [7:0] b, hold;
    int n;
    write_seq(8'h10, 1, 8'hA5, "R5");
    rand_read(8'h10, b); bus_stop();
    check("R8 R1 read 0x10", b, 8'hA5);
    hold = tx_big;
    // second write, then traffic during busy
    bus_start(); bus_sel(1'b0); bus_rx(8'h11); bus_rx(8'h5C); bus_stop();
    model[8'h11] = 8'h5C;
    check("R5 busy", busy_big, 1);
    bus_start(); bus_sel(1'b0); bus_rx(8'h20); bus_rx(8'h44); bus_stop();
    bus_start(); bus_sel(1'b1); bus_rd(b);
    check("R5 tx held in busy", b, hold);
    wait_idle(n);
    check("R5 busy not retriggered", n + 8, WR_CYC);
    rand_read(8'h20, b); bus_stop();
    check("R5 write in busy ignored", b, model[8'h20]);
  endtask

  task automatic t_page_wrap;
    logic [7:0] b;
    write_seq(8'h1D, 4, 8'h60, "R2");
    rand_read(8'h18, b);
    check("R2 page 0x18", b, model[8'h18]);
    check("R2 wrapped byte", model[8'h18], 8'h63);
    for (int i = 1; i < 8; i++) begin
      bus_rd(b);
      check("R2 page byte", b, model[8'h18 + 8'(i)]);
    end
    bus_stop();
  endtask

  task automatic t_overflow;
    logic [7:0] b;
    write_seq(8'h30, 10, 8'h80, "R3");
    rand_read(8'h30, b);
    check("R3 slot0 overwritten", b, 8'h88);
    bus_rd(b); check("R3 slot1 overwritten", b, 8'h89);
    bus_rd(b); check("R3 slot2 kept", b, 8'h82);
    bus_stop();
  endtask

  task automatic t_abandon;
    logic [7:0] b;
    bus_start(); bus_sel(1'b0); bus_rx(8'h40); bus_rx(8'h77);
    bus_start(); bus_sel(1'b1); bus_rd(b);
    check("R4 counter after data", b, model[8'h41]);
    bus_stop();
    check("R4 no busy", busy_big, 0);
    rand_read(8'h40, b); bus_stop();
    check("R4 array unchanged", b, model[8'h40]);
  endtask

  task automatic t_current_read;
    logic [7:0] b;
    rand_read(8'h1D, b); bus_stop();
    check("R8 read 0x1D", b, model[8'h1D]);
    bus_start(); bus_sel(1'b1); bus_rd(b); bus_stop();
    check("R6 current address", b, model[8'h1E]);
  endtask

  task automatic t_top_wrap;
    logic [7:0] b;
    write_seq(8'hFF, 1, 8'hEE, "R7");
    write_seq(8'h00, 1, 8'h11, "R7");
    rand_read(8'hFF, b);
    check("R7 top byte", b, 8'hEE);
    bus_rd(b); bus_stop();
    check("R7 wrap to 0", b, 8'h11);
  endtask

  task automatic t_addr_only;
    logic [7:0] b;
    write_seq(8'h60, 1, 8'h3C, "R11");
    bus_start(); bus_sel(1'b0); bus_rx(8'h60); bus_stop();
    check("R11 no busy", busy_big, 0);
    bus_start(); bus_sel(1'b1); bus_rd(b); bus_stop();
    check("R1 R11 current read", b, 8'h3C);
  endtask

  task automatic t_protect;
    logic [7:0] b;
    wp_i = 1'b1;
    write_seq(8'h50, 1, 8'h99, "R9");
    tick();
    check("R9 no busy later", busy_big, 0);
    wp_i = 1'b0;
    rand_read(8'h50, b); bus_stop();
    check("R9 array unchanged", b, model[8'h50]);
  endtask

  task automatic t_small;
    logic [7:0] b;
    write_seq(8'h85, 1, 8'h5A, "R10");
    rand_read(8'h05, b); bus_stop();
    check("R10 small ignores bit7", tx_small, 8'h5A);
    check("R10 big uses bit7", b, model[8'h05]);
    rand_read(8'h85, b); bus_stop();
    check("R10 big at 0x85", b, 8'h5A);
    rand_read(8'h7F, b);
    check("R10 small top", tx_small, 8'hEE);
    bus_rd(b); bus_stop();
    check("R10 R7 small wrap at 127", tx_small, 8'h11);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overflow();
    t_abandon();
    t_current_read();
    t_top_wrap();
    t_addr_only();
    t_protect();
    t_small();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule